// File: doc/BRIEF.md
# Cycle-Stealing Scrub Scheduler

This block decides when a memory protected by error correction gives up one access slot so that one stored word can be read back, corrected and rewritten. Each such stolen cycle covers the next word address in sequence, and the address wraps to zero after the last word. The memory-side logic does the correction work. It answers each request with a one-cycle done pulse. While a scrub is in flight the block raises a host-block signal, and the host interface uses that signal to ignore its own control inputs and to insert wait states.

The block has two modes. In master mode an internal timer starts a scrub once per period, whatever the host is doing. The period comes from a 4-bit exponential code. Each scrub drives an active-low busy warning first, then after a programmable lead time an active-low scrub strobe. In slave mode the timer is idle and both outputs stay high. Each falling edge of an external active-low scrub strobe, normally another block's master strobe, starts exactly one scrub. All times are whole clock cycles derived from a clock-period parameter `CLK_NS`. Two derived values are used: STEP is ceil(50/CLK_NS) and BASE is ceil(200/CLK_NS). With the default 8 ns clock, STEP is 7 and BASE is 25.

Top module: `scrub_sched`

## Requirements
- R1: During reset and straight after it: busy_n_o=1, scrub_n_o=1, scrub_req_o=0, host_block_o=0 and scrub_addr_o=0.
- R2: In master mode busy_n_o falls once every P(n)=2^n*STEP+BASE cycles, where n is the period code in force for that interval.
- R3: Each scrub raises scrub_req_o with scrub_addr_o holding the address due next. The address goes up by one on the cycle after scrub_done_i is sampled high while scrub_req_o is high.
- R4: scrub_n_o falls exactly lead*STEP cycles after busy_n_o falls, where lead is the lead-time code sampled when the scrub starts. Lead code 0 makes both fall in the same cycle, and scrub_n_o is never low while busy_n_o is high.
- R5: scrub_n_o stays low for BASE cycles, or longer until the done handshake has occurred. busy_n_o rises exactly STEP cycles after scrub_n_o rises.
- R6: host_block_o is high in every cycle where busy_n_o is low, in every cycle where scrub_req_o is high, and, in slave mode, while the synchronized scrub input is low.
- R7: Period codes 0, 1 and 2 behave as code 3 (P=8*STEP+BASE).
- R8: A period code change does not alter the interval already counting. It takes effect from the next interval boundary.
- R9: In slave mode busy_n_o and scrub_n_o stay high and the timer starts nothing. Each falling edge of scrub_n_i produces one scrub request within 4 cycles.
- R10: A scrub_n_i low pulse of a single clock cycle still produces exactly one scrub.
- R11: After the highest address 2^AW-1 the next scrub address is 0.
- R12: After reset the first interval uses the default period code DEF_PERIOD (7), so the first busy_n_o fall comes P(7) cycles after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slave_mode_i | input | 1 | 1 = follow external strobe, 0 = internal timer |
| period_code_i | input | 4 | Scrub period code n, P = 2^n*STEP+BASE cycles |
| lead_code_i | input | 4 | Busy-to-strobe lead code, lead*STEP cycles |
| scrub_n_i | input | 1 | External scrub strobe, active low (slave mode) |
| scrub_done_i | input | 1 | One-cycle completion pulse from the memory |
| scrub_req_o | output | 1 | Scrub request to the memory, held until done |
| scrub_addr_o | output | AW | Word address to scrub |
| busy_n_o | output | 1 | Early busy warning, active low (master mode) |
| scrub_n_o | output | 1 | Scrub strobe, active low (master mode) |
| host_block_o | output | 1 | Host control inputs must be ignored |

## Verification
The cases hardest to reach from the ports are the interval boundaries: a period change that must not touch the interval already counting, and a reserved code that must fall back to the shortest period. The stimulus changes the code just after a busy fall. It then measures two successive busy-to-busy intervals, expecting the old length first and the new length second. Codes 4 and then 0 are used so that the clamped value of 3 is told apart from "no change". The address wrap is reached by building the bench with a 3-bit address, so that a run of master scrubs passes through 7 to 0. A one-cycle external strobe pulse checks the single-request rule in slave mode.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_STROBE,
    ST_TAIL
  } seq_state_e;

  localparam int unsigned MIN_PERIOD_CODE = 3;
endpackage

// File: rtl/scrub_period_timer.sv
module scrub_period_timer
  import scrub_pkg::*;
#(
  parameter int unsigned TW       = 32,
  parameter int unsigned STEP_CYC = 7,
  parameter int unsigned BASE_CYC = 25,
  parameter int unsigned DEF_CODE = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [3:0] code_i,
  output logic       tick_o
);
  function automatic logic [TW-1:0] period_of(input logic [3:0] code);
    int unsigned n;
    n = (int'(code) < int'(MIN_PERIOD_CODE)) ? MIN_PERIOD_CODE : int'(code);
    return ((TW'(1) << n) * TW'(STEP_CYC)) + TW'(BASE_CYC);
  endfunction

  localparam logic [TW-1:0] DEF_LOAD = period_of(4'(DEF_CODE)) - TW'(1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= DEF_LOAD;
    end else if (en_i) begin
      if (cnt_q == '0) cnt_q <= period_of(code_i) - TW'(1);  // boundary: new code
      else             cnt_q <= cnt_q - TW'(1);
    end
  end

  assign tick_o = en_i && (cnt_q == '0);
endmodule

// File: rtl/scrub_master_seq.sv
module scrub_master_seq
  import scrub_pkg::*;
#(
  parameter int unsigned CW       = 7,
  parameter int unsigned STEP_CYC = 7,
  parameter int unsigned LOW_CYC  = 25,
  parameter int unsigned TAIL_CYC = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic [3:0] lead_code_i,
  input  logic       done_i,
  output logic       busy_n_o,
  output logic       scrub_n_o,
  output logic       req_o
);
  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          done_seen_q;
  logic          start;
  logic [CW-1:0] lead_cyc;

  assign start    = en_i && (state_q == ST_IDLE) && (tick_i || pend_q);
  assign lead_cyc = CW'(lead_code_i) * CW'(STEP_CYC);

  // a period that expires mid-scrub is remembered, not dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           pend_q <= 1'b0;
    else if (!en_i || start)               pend_q <= 1'b0;
    else if (tick_i && state_q != ST_IDLE) pend_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      done_seen_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            done_seen_q <= 1'b0;
            if (lead_cyc == '0) begin
              state_q <= ST_STROBE;
              cnt_q   <= CW'(LOW_CYC - 1);
            end else begin
              state_q <= ST_LEAD;
              cnt_q   <= lead_cyc - CW'(1);
            end
          end
        end
        ST_LEAD: begin
          if (cnt_q == '0) begin
            state_q <= ST_STROBE;
            cnt_q   <= CW'(LOW_CYC - 1);
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_STROBE: begin
          if (done_i) done_seen_q <= 1'b1;
          if (cnt_q == '0 && (done_seen_q || done_i)) begin
            state_q <= ST_TAIL;
            cnt_q   <= CW'(TAIL_CYC - 1);
          end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_TAIL: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - CW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_n_o  = (state_q == ST_IDLE);
  assign scrub_n_o = (state_q != ST_STROBE);
  assign req_o     = (state_q == ST_STROBE) && !done_seen_q;
endmodule

// File: rtl/scrub_slave_trig.sv
module scrub_slave_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic scrub_n_i,
  input  logic done_i,
  output logic req_o,
  output logic low_o
);
  logic s1_q, s2_q, prev_q, pend_q, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= scrub_n_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign fall = en_i && prev_q && !s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pend_q <= 1'b0;
    else if (fall)           pend_q <= 1'b1;
    else if (done_i && pend_q) pend_q <= 1'b0;
  end

  assign req_o = pend_q;
  assign low_o = en_i && !s2_q;
endmodule

// File: rtl/scrub_sched.sv
module scrub_sched #(
  parameter int unsigned CLK_NS     = 8,
  parameter int unsigned AW         = 19,
  parameter int unsigned TW         = 32,
  parameter int unsigned DEF_PERIOD = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slave_mode_i,
  input  logic [3:0]    period_code_i,
  input  logic [3:0]    lead_code_i,
  input  logic          scrub_n_i,
  input  logic          scrub_done_i,
  output logic          scrub_req_o,
  output logic [AW-1:0] scrub_addr_o,
  output logic          busy_n_o,
  output logic          scrub_n_o,
  output logic          host_block_o
);
  localparam int unsigned STEP_CYC = (50 + CLK_NS - 1) / CLK_NS;
  localparam int unsigned LOW_CYC  = (200 + CLK_NS - 1) / CLK_NS;
  localparam int unsigned TAIL_CYC = STEP_CYC;
  localparam int unsigned LEAD_MAX = 15 * STEP_CYC;
  localparam int unsigned CNT_MAX  = (LEAD_MAX > LOW_CYC) ? LEAD_MAX : LOW_CYC;
  localparam int unsigned CW       = $clog2(CNT_MAX + 1);

  logic tick, m_req, s_req, s_low;

  scrub_period_timer #(
    .TW(TW), .STEP_CYC(STEP_CYC), .BASE_CYC(LOW_CYC), .DEF_CODE(DEF_PERIOD)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (!slave_mode_i),
    .code_i(period_code_i),
    .tick_o(tick)
  );

  scrub_master_seq #(
    .CW(CW), .STEP_CYC(STEP_CYC), .LOW_CYC(LOW_CYC), .TAIL_CYC(TAIL_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (!slave_mode_i),
    .tick_i     (tick),
    .lead_code_i(lead_code_i),
    .done_i     (scrub_done_i),
    .busy_n_o   (busy_n_o),
    .scrub_n_o  (scrub_n_o),
    .req_o      (m_req)
  );

  scrub_slave_trig u_slave (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (slave_mode_i),
    .scrub_n_i(scrub_n_i),
    .done_i   (scrub_done_i),
    .req_o    (s_req),
    .low_o    (s_low)
  );

  assign scrub_req_o  = m_req || s_req;
  assign host_block_o = !busy_n_o || s_low || s_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          scrub_addr_o <= '0;
    else if (scrub_done_i && scrub_req_o) scrub_addr_o <= scrub_addr_o + AW'(1);
  end
endmodule

// File: rtl/scrub_sched_chk.sv
module scrub_sched_chk #(
  parameter int unsigned AW      = 19,
  parameter int unsigned LOW_CYC = 25
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          slave_mode_i,
  input logic          scrub_req_o,
  input logic [AW-1:0] scrub_addr_o,
  input logic          busy_n_o,
  input logic          scrub_n_o,
  input logic          host_block_o
);
  logic [15:0] lo_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          lo_cnt_q <= '0;
    else if (scrub_n_o)   lo_cnt_q <= '0;
    else if (lo_cnt_q != 16'hffff) lo_cnt_q <= lo_cnt_q + 16'd1;
  end

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scrub_addr_o) |-> scrub_addr_o == AW'($past(scrub_addr_o) + AW'(1)));

  assert_strobe_inside_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scrub_n_o |-> !busy_n_o);

  assert_strobe_low_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scrub_n_o) |-> lo_cnt_q >= 16'(LOW_CYC));

  assert_busy_after_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_n_o) |-> $past(scrub_n_o));

  assert_block_cover_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scrub_req_o || !busy_n_o) |-> host_block_o);

  assert_slave_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_mode_i && $past(slave_mode_i) && $past(busy_n_o)) |-> busy_n_o);
endmodule

bind scrub_sched scrub_sched_chk #(.AW(AW), .LOW_CYC(LOW_CYC)) u_chk (.*);

// File: tb/scrub_sched_test.sv
`timescale 1ns/1ps
module scrub_sched_test;
  localparam int AW   = 3;
  localparam int NW   = 1 << AW;
  localparam int STEP = 7;   // ceil(50/8)
  localparam int BASE = 25;  // ceil(200/8)

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slave_mode = 1'b0;
  logic [3:0]    period_code = 4'd7;
  logic [3:0]    lead_code = 4'd10;
  logic          scrub_n_in = 1'b1;
  logic          scrub_done = 1'b0;
  logic          scrub_req;
  logic [AW-1:0] scrub_addr;
  logic          busy_n, scrub_n_out, host_block;

  int n_checks = 0, n_err = 0, cyc = 0, n_done = 0;
  int model_addr = 0, last_bf = 0;
  bit finished = 1'b0;
  int exp_q[$];

  scrub_sched #(.CLK_NS(8), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .slave_mode_i(slave_mode),
    .period_code_i(period_code), .lead_code_i(lead_code),
    .scrub_n_i(scrub_n_in), .scrub_done_i(scrub_done),
    .scrub_req_o(scrub_req), .scrub_addr_o(scrub_addr),
    .busy_n_o(busy_n), .scrub_n_o(scrub_n_out), .host_block_o(host_block)
  );

  initial forever #4 clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  function automatic int per(input int n);
    int m;
    m = (n < 3) ? 3 : n;
    return (1 << m) * STEP + BASE;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // memory model + scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (scrub_done) scrub_done = 1'b0;
    else if (rst_n && scrub_req) begin
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected scrub", int'(scrub_addr), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        if (e == 0 && n_done > 0) check(int'(scrub_addr) == e, "R11 wrap", int'(scrub_addr), e);
        else                      check(int'(scrub_addr) == e, "R3 address", int'(scrub_addr), e);
      end
      scrub_done = 1'b1;
      n_done++;
    end
    if (rst_n && !slave_mode)
      check(host_block == !busy_n, "R6 block", int'(host_block), int'(!busy_n));
  end

  task automatic master_scrub(input int exp_int, input string itag, input int lead);
    int t_bf, t_sf, t_sr, t_br;
    exp_q.push_back(model_addr);
    model_addr = (model_addr + 1) % NW;
    do @(negedge clk); while (busy_n);
    t_bf = cyc;
    check(t_bf - last_bf == exp_int, itag, t_bf - last_bf, exp_int);
    last_bf = t_bf;
    while (scrub_n_out) @(negedge clk);
    t_sf = cyc;
    check(t_sf - t_bf == lead * STEP, "R4 lead", t_sf - t_bf, lead * STEP);
    while (!scrub_n_out) @(negedge clk);
    t_sr = cyc;
    check(t_sr - t_sf == BASE, "R5 strobe width", t_sr - t_sf, BASE);
    while (!busy_n) @(negedge clk);
    t_br = cyc;
    check(t_br - t_sr == STEP, "R5 busy tail", t_br - t_sr, STEP);
  endtask

  task automatic slave_pulse(input int low_cycles, input string tag);
    int d0;
    exp_q.push_back(model_addr);
    model_addr = (model_addr + 1) % NW;
    d0 = n_done;
    @(negedge clk);
    scrub_n_in = 1'b0;
    for (int i = 0; i < low_cycles; i++) begin
      @(negedge clk);
      if (i == 5) check(n_done == d0 + 1, "R9 request latency", n_done - d0, 1);
      if (i == 20) begin
        check(host_block == 1'b1, "R6 slave block", int'(host_block), 1);
        check(busy_n && scrub_n_out, "R9 outputs quiet", int'(busy_n && scrub_n_out), 1);
      end
    end
    scrub_n_in = 1'b1;
    repeat (60) @(negedge clk);
    check(n_done == d0 + 1, tag, n_done - d0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy_n == 1 && scrub_n_out == 1, "R1 strobes idle", int'({busy_n, scrub_n_out}), 3);
    check(scrub_req == 0 && host_block == 0, "R1 req/block", int'({scrub_req, host_block}), 0);
    check(scrub_addr == 0, "R1 address", int'(scrub_addr), 0);
    rst_n = 1'b1;
    last_bf = cyc;
    @(negedge clk);
    check(busy_n == 1 && scrub_addr == 0, "R1 after release", int'(busy_n), 1);

    master_scrub(per(7), "R12 first interval", 10);
    period_code = 4'd3; lead_code = 4'd2;
    master_scrub(per(7), "R8 old period kept", 2);
    master_scrub(per(3), "R2 period code 3", 2);
    period_code = 4'd4; lead_code = 4'd0;
    master_scrub(per(3), "R8 old period kept", 0);
    master_scrub(per(4), "R2 period code 4", 0);
    period_code = 4'd0;
    master_scrub(per(4), "R8 old period kept", 0);
    master_scrub(per(3), "R7 reserved code clamped", 0);
    master_scrub(per(3), "R2 period code 3", 0);
    master_scrub(per(3), "R2 period code 3", 0);
    master_scrub(per(3), "R2 period code 3", 0);

    slave_mode = 1'b1;
    begin
      int falls = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (!busy_n || !scrub_n_out) falls++;
      end
      check(falls == 0, "R9 timer idle", falls, 0);
    end
    slave_pulse(30, "R9 one scrub per edge");
    slave_pulse(1, "R10 short pulse");
    slave_pulse(40, "R9 one scrub per edge");

    check(exp_q.size() == 0, "R3 all scrubs seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule